// File: doc/BRIEF.md
# Dual Operand Address Generator

This block computes two operand addresses in the same cycle for dual-operand multiply-accumulate style operations. One operand lives in an X data space and the other in a Y data space. Each side has its own pointer selector, addressing mode, post-modify step and optional index value. The caller also supplies the current pointer and index register contents. The block returns the effective address for each side, the updated pointer value with its write-back enable, and a fault indication.

Only four pointer registers may be used. Registers 8 and 9 serve the X side and registers 10 and 11 serve the Y side. Indexed addressing is open only to register 9 on X and register 11 on Y. The inclusive address window of each space is held in four bound registers, which are loaded through a small write port. A side whose address, or whose updated pointer, falls outside its window is faulted, and that side's pointer write-back is withheld.

All results are registered. A request made in cycle N is answered in cycle N+1 with a single valid strobe that covers both sides.

Top module: `dual_operand_agu`

## Requirements
- R1: After reset, `out_valid`, both write-back enables, both fault flags and `err` are 0. A request with `req_valid` high in cycle N yields `out_valid` high in cycle N+1. With `req_valid` low, `out_valid`, the write-back enables, the faults and `err` are 0 in the next cycle.
- R2: The X side accepts only selector values 8 and 9, and the Y side accepts only 10 and 11. Any other selector value faults that side.
- R3: Mode code 0 (plain indirect) gives an effective address equal to the pointer value and leaves the write-back enable at 0.
- R4: Mode code 1 (post-modify) gives an effective address equal to the pointer value. The write-back value is the pointer plus the step, modulo 2^AW, and the write-back enable is 1 when the side is not faulted. The step code bits [1:0] times 2 give the magnitude (0, 2, 4 or 6), and bit 2 set makes the step negative.
- R5: Mode code 2 (indexed) gives an effective address of pointer plus index, modulo 2^AW, with no write-back. It is legal only with selector 9 on X or selector 11 on Y; any other selector in this mode faults that side.
- R6: Mode code 3 is illegal and faults the side.
- R7: A side faults when its effective address lies below its lower bound or above its upper bound. In mode 1 it also faults when the updated pointer lies outside the window. Both bounds are inclusive.
- R8: A fault withholds the write-back of the faulting side only. The other side's results are unaffected.
- R9: `bnd_sel` picks the bound register written when `bnd_we` is high: 0 is the X lower bound, 1 the X upper bound, 2 the Y lower bound and 3 the Y upper bound. After reset the lower bounds are 0 and the upper bounds are all ones. A request made in the same cycle as a bound write is judged against the bounds held before the write.
- R10: `err` is 1 in a result cycle exactly when at least one side faulted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe for both sides |
| x_sel | input | 4 | X pointer register selector |
| x_mode | input | 2 | X addressing mode code |
| x_step | input | 3 | X post-modify step code |
| x_ptr | input | AW | Current X pointer value |
| x_idx | input | AW | X index register value |
| y_sel | input | 4 | Y pointer register selector |
| y_mode | input | 2 | Y addressing mode code |
| y_step | input | 3 | Y post-modify step code |
| y_ptr | input | AW | Current Y pointer value |
| y_idx | input | AW | Y index register value |
| bnd_we | input | 1 | Bound register write enable |
| bnd_sel | input | 2 | Bound register select |
| bnd_wdata | input | AW | Bound register write data |
| out_valid | output | 1 | Result strobe |
| x_ea | output | AW | X effective address |
| x_wb_en | output | 1 | X pointer write-back enable |
| x_wb_val | output | AW | X updated pointer value |
| x_fault | output | 1 | X side fault |
| y_ea | output | AW | Y effective address |
| y_wb_en | output | 1 | Y pointer write-back enable |
| y_wb_val | output | AW | Y updated pointer value |
| y_fault | output | 1 | Y side fault |
| err | output | 1 | Any side faulted |

## Verification
A bound-register write and an address request can land in the same cycle, so the window a request is judged against can change underneath it. The bench narrows the X window with a write in the very cycle that a request would fall outside the new window but inside the old one. It expects that request to pass. It then repeats the request one cycle later and expects a fault with the write-back withheld. A second coincidence is a fault on one side while the other side performs a legal post-modify. Here the bench checks that only the faulting side loses its write-back.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    AM_IND  = 2'd0,
    AM_POST = 2'd1,
    AM_IDX  = 2'd2,
    AM_BAD  = 2'd3
  } agu_mode_e;

  // signed byte offset for a 3-bit step code: magnitude = code[1:0]*2, code[2] = negative
  function automatic logic signed [3:0] step_offset(input logic [2:0] code);
    logic signed [3:0] mag;
    mag = $signed({1'b0, code[1:0], 1'b0});
    return code[2] ? -mag : mag;
  endfunction

  // inclusive window test on zero-extended values
  function automatic logic in_window(input logic [31:0] a, input logic [31:0] lo,
                                     input logic [31:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

endpackage

// File: rtl/agu_bounds.sv
module agu_bounds #(
  parameter int AW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [1:0]          wsel,
  input  logic [AW-1:0]       wdata,
  output logic [1:0][AW-1:0]  lo,
  output logic [1:0][AW-1:0]  hi
);
  localparam logic [AW-1:0] TOP_ADDR = {AW{1'b1}};

  for (genvar s = 0; s < 2; s++) begin : g_side
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo[s] <= '0;
        hi[s] <= TOP_ADDR;
      end else if (we && wsel[1] == 1'(s)) begin
        if (wsel[0]) hi[s] <= wdata;
        else         lo[s] <= wdata;
      end
    end
  end
endmodule

// File: rtl/agu_lane.sv
module agu_lane
  import agu_pkg::*;
#(
  parameter int AW       = 16,
  parameter int BASE_SEL = 8
) (
  input  logic [3:0]    sel,
  input  logic [1:0]    mode,
  input  logic [2:0]    step,
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] idx,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] upd,
  output logic          wb_en,
  output logic          fault
);
  localparam logic [3:0] SEL_A = 4'(BASE_SEL);
  localparam logic [3:0] SEL_B = 4'(BASE_SEL + 1);

  agu_mode_e m;
  logic sel_ok, mode_ok, ea_ok, upd_ok;
  logic signed [3:0] off;

  always_comb begin
    m       = agu_mode_e'(mode);
    off     = step_offset(step);
    sel_ok  = (sel == SEL_A) || (sel == SEL_B);
    mode_ok = (m != AM_BAD) && !((m == AM_IDX) && (sel != SEL_B));
    ea      = (m == AM_IDX) ? ptr + idx : ptr;
    upd     = ptr + {{(AW-4){off[3]}}, off};
    ea_ok   = in_window(32'(ea), 32'(lo), 32'(hi));
    upd_ok  = (m != AM_POST) || in_window(32'(upd), 32'(lo), 32'(hi));
    fault   = !(sel_ok && mode_ok && ea_ok && upd_ok);
    wb_en   = (m == AM_POST) && !fault;
  end
endmodule

// File: rtl/dual_operand_agu.sv
module dual_operand_agu
  import agu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [3:0]    x_sel,
  input  logic [1:0]    x_mode,
  input  logic [2:0]    x_step,
  input  logic [AW-1:0] x_ptr,
  input  logic [AW-1:0] x_idx,
  input  logic [3:0]    y_sel,
  input  logic [1:0]    y_mode,
  input  logic [2:0]    y_step,
  input  logic [AW-1:0] y_ptr,
  input  logic [AW-1:0] y_idx,
  input  logic          bnd_we,
  input  logic [1:0]    bnd_sel,
  input  logic [AW-1:0] bnd_wdata,
  output logic          out_valid,
  output logic [AW-1:0] x_ea,
  output logic          x_wb_en,
  output logic [AW-1:0] x_wb_val,
  output logic          x_fault,
  output logic [AW-1:0] y_ea,
  output logic          y_wb_en,
  output logic [AW-1:0] y_wb_val,
  output logic          y_fault,
  output logic          err
);
  localparam int NSIDE = 2;

  logic [1:0][AW-1:0] bnd_lo, bnd_hi;
  logic [NSIDE-1:0][3:0]    sel_a;
  logic [NSIDE-1:0][1:0]    mode_a;
  logic [NSIDE-1:0][2:0]    step_a;
  logic [NSIDE-1:0][AW-1:0] ptr_a, idx_a, ea_a, upd_a;
  logic [NSIDE-1:0]         wb_a, flt_a;

  assign sel_a  = {y_sel, x_sel};
  assign mode_a = {y_mode, x_mode};
  assign step_a = {y_step, x_step};
  assign ptr_a  = {y_ptr, x_ptr};
  assign idx_a  = {y_idx, x_idx};

  agu_bounds #(.AW(AW)) u_bounds (
    .clk(clk), .rst_n(rst_n), .we(bnd_we), .wsel(bnd_sel), .wdata(bnd_wdata),
    .lo(bnd_lo), .hi(bnd_hi)
  );

  for (genvar s = 0; s < NSIDE; s++) begin : g_lane
    agu_lane #(.AW(AW), .BASE_SEL(s == 0 ? 8 : 10)) u_lane (
      .sel(sel_a[s]), .mode(mode_a[s]), .step(step_a[s]),
      .ptr(ptr_a[s]), .idx(idx_a[s]), .lo(bnd_lo[s]), .hi(bnd_hi[s]),
      .ea(ea_a[s]), .upd(upd_a[s]), .wb_en(wb_a[s]), .fault(flt_a[s])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      x_ea <= '0; x_wb_val <= '0; x_wb_en <= 1'b0; x_fault <= 1'b0;
      y_ea <= '0; y_wb_val <= '0; y_wb_en <= 1'b0; y_fault <= 1'b0;
      err <= 1'b0;
    end else begin
      out_valid <= req_valid;
      x_ea      <= ea_a[0];
      x_wb_val  <= upd_a[0];
      y_ea      <= ea_a[1];
      y_wb_val  <= upd_a[1];
      x_wb_en   <= req_valid && wb_a[0];
      y_wb_en   <= req_valid && wb_a[1];
      x_fault   <= req_valid && flt_a[0];
      y_fault   <= req_valid && flt_a[1];
      err       <= req_valid && (|flt_a);
    end
  end
endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
  parameter int AW = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [3:0]         x_sel,
  input logic [1:0]         x_mode,
  input logic [3:0]         y_sel,
  input logic [1:0]         y_mode,
  input logic [1:0][AW-1:0] bnd_lo,
  input logic [1:0][AW-1:0] bnd_hi,
  input logic               out_valid,
  input logic [AW-1:0]      x_ea,
  input logic               x_wb_en,
  input logic [AW-1:0]      x_wb_val,
  input logic               x_fault,
  input logic [AW-1:0]      y_ea,
  input logic               y_wb_en,
  input logic [AW-1:0]      y_wb_val,
  input logic               y_fault,
  input logic               err
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid && !err && !x_wb_en && !y_wb_en);

  a_r2_x_sel: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && x_sel != 4'd8 && x_sel != 4'd9 |=> x_fault);

  a_r2_y_sel: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && y_sel != 4'd10 && y_sel != 4'd11 |=> y_fault);

  a_r5_x_index_reg: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && x_mode == 2'd2 && x_sel != 4'd9 |=> x_fault);

  a_r6_y_bad_mode: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && y_mode == 2'd3 |=> y_fault && err);

  a_r4_wb_only_post: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && x_mode != 2'd1 && y_mode != 2'd1 |=> !x_wb_en && !y_wb_en);

  a_r7_x_ea_window: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !x_fault |-> x_ea >= $past(bnd_lo[0]) && x_ea <= $past(bnd_hi[0]));

  a_r7_y_wb_window: assert property (@(posedge clk) disable iff (!rst_n)
    y_wb_en |-> y_wb_val >= $past(bnd_lo[1]) && y_wb_val <= $past(bnd_hi[1]));

  a_r8_fault_blocks_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (x_fault |-> !x_wb_en) and (y_fault |-> !y_wb_en));
endmodule

bind dual_operand_agu agu_checker #(.AW(AW)) u_chk (.*);

// File: tb/sim_dual_operand_agu.sv
`timescale 1ns/1ps
module sim_dual_operand_agu;
  localparam int AW = 16;

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [3:0] x_sel = '0, y_sel = '0;
  logic [1:0] x_mode = '0, y_mode = '0;
  logic [2:0] x_step = '0, y_step = '0;
  logic [AW-1:0] x_ptr = '0, x_idx = '0, y_ptr = '0, y_idx = '0;
  logic bnd_we = 1'b0;
  logic [1:0] bnd_sel = '0;
  logic [AW-1:0] bnd_wdata = '0;
  logic out_valid, x_wb_en, x_fault, y_wb_en, y_fault, err;
  logic [AW-1:0] x_ea, x_wb_val, y_ea, y_wb_val;

  int checks = 0, fails = 0;
  int lo_m[2], hi_m[2];
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_operand_agu #(.AW(AW)) u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // independent reference of one side
  task automatic ref_side(input int side, input int sel, input int mode, input int step,
                          input int ptr, input int idx,
                          output int ea, output int wbv, output int wben, output int flt);
    int base, off;
    base = (side == 0) ? 8 : 10;
    off  = (step % 4) * 2;
    if (step >= 4) off = -off;
    flt  = !(sel == base || sel == base + 1);
    if (mode == 3) flt = 1;
    if (mode == 2 && sel != base + 1) flt = 1;
    ea   = (mode == 2) ? ((ptr + idx) & 32'hFFFF) : ptr;
    wbv  = (ptr + off) & 32'hFFFF;
    if (ea < lo_m[side] || ea > hi_m[side]) flt = 1;
    if (mode == 1 && (wbv < lo_m[side] || wbv > hi_m[side])) flt = 1;
    wben = (mode == 1 && !flt) ? 1 : 0;
  endtask

  // issue one request, optionally with a bound write in the same cycle, and check results
  task automatic pair(input string req,
                      input int xs, input int xm, input int xt, input int xp, input int xi,
                      input int ys, input int ym, input int yt, input int yp, input int yi,
                      input bit wr = 0, input int wsel = 0, input int wdat = 0);
    int ea, wbv, wbe, flt, anyf;
    x_sel = 4'(xs); x_mode = 2'(xm); x_step = 3'(xt); x_ptr = AW'(xp); x_idx = AW'(xi);
    y_sel = 4'(ys); y_mode = 2'(ym); y_step = 3'(yt); y_ptr = AW'(yp); y_idx = AW'(yi);
    bnd_we = wr; bnd_sel = 2'(wsel); bnd_wdata = AW'(wdat);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; bnd_we = 1'b0;
    chk({req, " R1 valid"}, out_valid, 1);
    ref_side(0, xs, xm, xt, xp, xi, ea, wbv, wbe, flt);
    anyf = flt;
    chk({req, " x_ea"}, x_ea, ea);
    chk({req, " x_wb_en"}, x_wb_en, wbe);
    if (wbe) chk({req, " x_wb_val"}, x_wb_val, wbv);
    chk({req, " x_fault"}, x_fault, flt);
    ref_side(1, ys, ym, yt, yp, yi, ea, wbv, wbe, flt);
    anyf = anyf | flt;
    chk({req, " y_ea"}, y_ea, ea);
    chk({req, " y_wb_en"}, y_wb_en, wbe);
    if (wbe) chk({req, " y_wb_val"}, y_wb_val, wbv);
    chk({req, " y_fault"}, y_fault, flt);
    chk({req, " R10 err"}, err, anyf);
    if (wr) begin
      if (wsel[0]) hi_m[wsel/2] = wdat; else lo_m[wsel/2] = wdat;
    end
  endtask

  task automatic t_reset;
    chk("R1 reset valid", out_valid, 0);
    chk("R1 reset wb", {x_wb_en, y_wb_en}, 0);
    chk("R1 reset fault", {x_fault, y_fault, err}, 0);
  endtask

  task automatic t_indirect;
    pair("R3 indirect", 8, 0, 3, 'h0100, 0, 11, 0, 5, 'h0200, 0);
    pair("R3 indirect b", 9, 0, 0, 'hFFFE, 0, 10, 0, 0, 'h0000, 0);
  endtask

  task automatic t_postmod;
    for (int c = 0; c < 8; c++)
      pair($sformatf("R4 step %0d", c), 8 + (c % 2), 1, c, 'h4000, 0, 10 + (c % 2), 1, 7 - c, 'h6000, 0);
    pair("R4 wrap", 9, 1, 3, 'hFFFE, 0, 11, 1, 6, 'h0002, 0);
  endtask

  task automatic t_indexed;
    pair("R5 indexed ok", 9, 2, 0, 'h1000, 'h0024, 11, 2, 0, 'h2000, 'hFFFE);
    pair("R5 indexed bad reg", 8, 2, 0, 'h1000, 'h4, 10, 2, 0, 'h2000, 'h6);
  endtask

  task automatic t_badsel;
    pair("R2 swapped", 10, 0, 0, 'h10, 0, 8, 0, 0, 'h20, 0);
    pair("R2 low regs", 0, 1, 1, 'h10, 0, 7, 1, 1, 'h20, 0);
    pair("R2 high regs", 12, 0, 0, 'h10, 0, 15, 0, 0, 'h20, 0);
  endtask

  task automatic t_badmode;
    pair("R6 mode3", 8, 3, 0, 'h10, 0, 11, 3, 0, 'h20, 0);
  endtask

  task automatic t_range;
    pair("R9 set xlo", 8, 0, 0, 0, 0, 10, 0, 0, 0, 0, 1, 0, 'h1000);
    pair("R9 set xhi", 8, 0, 0, 'h1000, 0, 10, 0, 0, 0, 0, 1, 1, 'h17FE);
    pair("R9 set ylo", 8, 0, 0, 'h1000, 0, 10, 0, 0, 0, 0, 1, 2, 'h8000);
    pair("R9 set yhi", 8, 0, 0, 'h1000, 0, 10, 0, 0, 'h8000, 0, 1, 3, 'h80FF);
    pair("R7 upd above hi R8", 8, 1, 1, 'h17FE, 0, 10, 1, 2, 'h8000, 0);
    pair("R7 at hi no step", 9, 1, 0, 'h17FE, 0, 11, 1, 5, 'h8002, 0);
    pair("R7 upd below lo", 8, 1, 5, 'h1000, 0, 11, 1, 5, 'h8000, 0);
    pair("R7 ea below lo", 8, 0, 0, 'h0FFF, 0, 10, 0, 0, 'h80FF, 0);
    pair("R7 idx above hi", 9, 2, 0, 'h17F0, 'h10, 11, 2, 0, 'h8000, 'h100);
  endtask

  task automatic t_same_cycle;
    pair("R9 old bound same cycle", 8, 1, 2, 'h1700, 0, 10, 0, 0, 'h8010, 0, 1, 1, 'h16FE);
    pair("R9 new bound next", 8, 1, 2, 'h1700, 0, 10, 0, 0, 'h8010, 0);
  endtask

  task automatic t_idle;
    x_sel = 4'd3; x_mode = 2'd3;
    @(negedge clk);
    chk("R1 idle valid", out_valid, 0);
    chk("R1 idle flags", {x_fault, y_fault, err, x_wb_en, y_wb_en}, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    lo_m[0] = 0; lo_m[1] = 0; hi_m[0] = 'hFFFF; hi_m[1] = 'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_indirect();
    t_postmod();
    t_indexed();
    t_badsel();
    t_badmode();
    t_idle();
    t_range();
    t_same_cycle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule